// File: doc/BRIEF.md
# Fully Associative Two-Word-Line Cache with Victim Buffer

This block sits between a processor load/store port and a memory with a 64-bit read path. The main array is fully associative. Every stored tag is compared against the request address in the same cycle. Each line holds an even and an odd 32-bit word. The two words are fetched together as one 64-bit beat on a read miss. Each word has its own valid bit, so a store can place a line tag while marking only the written word present.

Lines pushed out of the main array are kept in a small fully associative victim buffer. The victim buffer is searched whenever the main array misses. A victim hit answers the processor without a memory access, and the line then trades places with the main array's replacement candidate. Stores are write-through: every store writes memory, and the processor is stalled until memory acknowledges the write.

The processor raises `cpu_req` for one cycle while `cpu_stall` is low. The result appears as a one-cycle `cpu_done` pulse, together with `cpu_rdata` and `cpu_hit`.

Top module: `assoc_victim_cache`

## Requirements
- R1: A read whose word is present in the main array returns its data with `cpu_done` and `cpu_hit` high in the cycle after the request. It issues no memory request.
- R2: When the main array is full, a new line replaces the least recently used line. Recency is updated by every read hit, store hit, store allocation, fill and victim swap.
- R3: A read miss issues one memory read at the line address, which has address bits [2:0] zero. The low 32 bits of `mem_rdata` become the even word (address bit 2 = 0) and the high 32 bits become the odd word. Both words are then valid, and the read returns the requested word with `cpu_hit` low.
- R4: Even and odd words have separate valid bits. After a store allocates a line, a read of the other word in that line is a miss and refills the same line.
- R5: A store that misses both arrays allocates a main line holding only the stored word. No memory read is made.
- R6: A valid line displaced from the main array by a fill or store allocation goes into the victim buffer of `VICT_LINES` lines. The victim buffer overwrites its entries in first-in, first-out order, so the oldest displaced line is lost first.
- R7: A read that misses the main array but finds its word in the victim buffer returns the data in the cycle after the request with `cpu_hit` high and no memory access. That line moves into the main array's replacement slot, and the slot's previous line moves into the victim entry.
- R8: Every store drives `mem_req` and `mem_we` with the store address and data. A store that hits a line in either array updates that copy, and `cpu_hit` reports whether the store hit.
- R9: After reset, `cpu_stall`, `cpu_done` and `mem_req` are low, and every line in both arrays is invalid.
- R10: While a memory access is outstanding, `cpu_stall` is high and `mem_req` and `mem_addr` hold steady until `mem_ready`. `cpu_done` follows in the cycle after `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request strobe, taken only while `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address; bit 2 selects the odd word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Block busy with a memory access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | The request hit the main array or the victim buffer |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory access request, held until `mem_ready` |
| mem_we | output | 1 | Memory write (1) or line read (0) |
| mem_addr | output | ADDR_W | Word address for writes, line address for reads |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ready | input | 1 | Memory has completed the access |
| mem_rdata | input | 2*DATA_W | Two-word line, even word in the low half |

## Verification
Read hits in either array must show `cpu_done` at the first falling edge after the request edge. The bench samples there and counts the elapsed cycles, so a single extra register stage shows up as a latency miscompare. Misses and stores complete one cycle after the cycle in which the bench's memory model raises `mem_ready`, which it does on the second cycle of a request. The bench waits for `cpu_done` at falling edges and compares `cpu_stall` as seen one cycle after the request. A counter of memory line reads shows whether each result came from the arrays or from memory.

// File: rtl/avc_pkg.sv
package avc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_WRITE
  } avc_state_e;
endpackage

// File: rtl/avc_tag_match.sv
// Parallel tag comparator: one equality compare per entry, reduced to a hit and an index.
module avc_tag_match #(
  parameter int N     = 4,
  parameter int TAG_W = 29,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            live,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/avc_lru.sv
// Age-counter replacement: the ages form a permutation; age 0 is most recent.
module avc_lru #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     live,
  output logic [IDX_W-1:0] lru_idx
);
  logic [N-1:0][IDX_W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!live[i] && !found) begin
        lru_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/assoc_victim_cache.sv
module assoc_victim_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int MAIN_LINES = 4,
  parameter int VICT_LINES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic                  cpu_stall,
  output logic                  cpu_done,
  output logic                  cpu_hit,
  output logic [DATA_W-1:0]     cpu_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic [2*DATA_W-1:0]   mem_rdata
);
  import avc_pkg::*;

  localparam int OFF    = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - OFF - 1;
  localparam int MIDX_W = (MAIN_LINES > 1) ? $clog2(MAIN_LINES) : 1;
  localparam int VIDX_W = (VICT_LINES > 1) ? $clog2(VICT_LINES) : 1;

  avc_state_e state;

  logic [MAIN_LINES-1:0][TAG_W-1:0]  m_tag;
  logic [MAIN_LINES-1:0][DATA_W-1:0] m_d0, m_d1;
  logic [MAIN_LINES-1:0]             m_ve, m_vo;
  logic [VICT_LINES-1:0][TAG_W-1:0]  v_tag;
  logic [VICT_LINES-1:0][DATA_W-1:0] v_d0, v_d1;
  logic [VICT_LINES-1:0]             v_ve, v_vo;
  logic [VIDX_W-1:0]                 v_ptr, v_ptr_nx;

  logic [ADDR_W-1:0] q_addr;
  logic [MIDX_W-1:0] q_slot;
  logic              q_reuse, q_vkill;
  logic [VIDX_W-1:0] q_vidx;

  logic [TAG_W-1:0]  key;
  logic              sel;
  logic              mhit, vhit, m_word_ok, v_word_ok;
  logic [MIDX_W-1:0] midx, lru_idx, touch_idx;
  logic [VIDX_W-1:0] vidx;
  logic              touch;

  assign key      = cpu_addr[ADDR_W-1:OFF+1];
  assign sel      = cpu_addr[OFF];
  assign v_ptr_nx = (v_ptr == VIDX_W'(VICT_LINES - 1)) ? '0 : v_ptr + 1'b1;

  avc_tag_match #(.N(MAIN_LINES), .TAG_W(TAG_W)) i_main_cmp (
    .tags(m_tag), .live(m_ve | m_vo), .key(key), .hit(mhit), .idx(midx)
  );

  avc_tag_match #(.N(VICT_LINES), .TAG_W(TAG_W)) i_vict_cmp (
    .tags(v_tag), .live(v_ve | v_vo), .key(key), .hit(vhit), .idx(vidx)
  );

  avc_lru #(.N(MAIN_LINES)) i_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .live(m_ve | m_vo), .lru_idx(lru_idx)
  );

  assign m_word_ok = mhit && (sel ? m_vo[midx] : m_ve[midx]);
  assign v_word_ok = vhit && (sel ? v_vo[vidx] : v_ve[vidx]);

  // Recency update: every hit, allocation, swap and fill makes its slot newest.
  always_comb begin
    touch     = 1'b0;
    touch_idx = lru_idx;
    if (state == ST_IDLE && cpu_req) begin
      if (!cpu_we) begin
        if (m_word_ok) begin
          touch     = 1'b1;
          touch_idx = midx;
        end else if (v_word_ok) begin
          touch = 1'b1;
        end
      end else if (mhit) begin
        touch     = 1'b1;
        touch_idx = midx;
      end else if (!vhit) begin
        touch = 1'b1;
      end
    end else if (state == ST_FILL && mem_ready) begin
      touch     = 1'b1;
      touch_idx = q_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      m_ve      <= '0;
      m_vo      <= '0;
      v_ve      <= '0;
      v_vo      <= '0;
      v_ptr     <= '0;
      cpu_stall <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: if (cpu_req) begin
          q_addr <= cpu_addr;
          if (!cpu_we) begin
            if (m_word_ok) begin
              cpu_rdata <= sel ? m_d1[midx] : m_d0[midx];
              cpu_hit   <= 1'b1;
              cpu_done  <= 1'b1;
            end else if (v_word_ok) begin
              cpu_rdata        <= sel ? v_d1[vidx] : v_d0[vidx];
              cpu_hit          <= 1'b1;
              cpu_done         <= 1'b1;
              m_tag[lru_idx]   <= v_tag[vidx];
              m_ve[lru_idx]    <= v_ve[vidx];
              m_vo[lru_idx]    <= v_vo[vidx];
              m_d0[lru_idx]    <= v_d0[vidx];
              m_d1[lru_idx]    <= v_d1[vidx];
              v_tag[vidx]      <= m_tag[lru_idx];
              v_ve[vidx]       <= m_ve[lru_idx];
              v_vo[vidx]       <= m_vo[lru_idx];
              v_d0[vidx]       <= m_d0[lru_idx];
              v_d1[vidx]       <= m_d1[lru_idx];
            end else begin
              state     <= ST_FILL;
              cpu_stall <= 1'b1;
              mem_req   <= 1'b1;
              mem_we    <= 1'b0;
              mem_addr  <= {key, {(OFF + 1){1'b0}}};
              q_slot    <= mhit ? midx : lru_idx;
              q_reuse   <= mhit;
              q_vkill   <= vhit;
              q_vidx    <= vidx;
            end
          end else begin
            state     <= ST_WRITE;
            cpu_stall <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cpu_addr;
            mem_wdata <= cpu_wdata;
            if (mhit) begin
              cpu_hit <= 1'b1;
              if (sel) begin m_d1[midx] <= cpu_wdata; m_vo[midx] <= 1'b1; end
              else     begin m_d0[midx] <= cpu_wdata; m_ve[midx] <= 1'b1; end
            end else if (vhit) begin
              cpu_hit <= 1'b1;
              if (sel) begin v_d1[vidx] <= cpu_wdata; v_vo[vidx] <= 1'b1; end
              else     begin v_d0[vidx] <= cpu_wdata; v_ve[vidx] <= 1'b1; end
            end else begin
              cpu_hit <= 1'b0;
              if (m_ve[lru_idx] || m_vo[lru_idx]) begin
                v_tag[v_ptr] <= m_tag[lru_idx];
                v_ve[v_ptr]  <= m_ve[lru_idx];
                v_vo[v_ptr]  <= m_vo[lru_idx];
                v_d0[v_ptr]  <= m_d0[lru_idx];
                v_d1[v_ptr]  <= m_d1[lru_idx];
                v_ptr        <= v_ptr_nx;
              end
              m_tag[lru_idx] <= key;
              m_ve[lru_idx]  <= !sel;
              m_vo[lru_idx]  <= sel;
              if (sel) m_d1[lru_idx] <= cpu_wdata;
              else     m_d0[lru_idx] <= cpu_wdata;
            end
          end
        end
        ST_FILL: if (mem_ready) begin
          state     <= ST_IDLE;
          mem_req   <= 1'b0;
          cpu_stall <= 1'b0;
          cpu_done  <= 1'b1;
          cpu_hit   <= 1'b0;
          cpu_rdata <= q_addr[OFF] ? mem_rdata[2*DATA_W-1:DATA_W] : mem_rdata[DATA_W-1:0];
          if (q_vkill) begin
            v_ve[q_vidx] <= 1'b0;
            v_vo[q_vidx] <= 1'b0;
          end
          if (!q_reuse && (m_ve[q_slot] || m_vo[q_slot])) begin
            v_tag[v_ptr] <= m_tag[q_slot];
            v_ve[v_ptr]  <= m_ve[q_slot];
            v_vo[v_ptr]  <= m_vo[q_slot];
            v_d0[v_ptr]  <= m_d0[q_slot];
            v_d1[v_ptr]  <= m_d1[q_slot];
            v_ptr        <= v_ptr_nx;
          end
          m_tag[q_slot] <= q_addr[ADDR_W-1:OFF+1];
          m_ve[q_slot]  <= 1'b1;
          m_vo[q_slot]  <= 1'b1;
          m_d0[q_slot]  <= mem_rdata[DATA_W-1:0];
          m_d1[q_slot]  <= mem_rdata[2*DATA_W-1:DATA_W];
        end
        ST_WRITE: if (mem_ready) begin
          state     <= ST_IDLE;
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          cpu_stall <= 1'b0;
          cpu_done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/avc_checker.sv
module avc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_ACCEPT_RESOLVES: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall) |=> (cpu_done || mem_req)); // R1

  AST_STORE_WRITES_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && cpu_we) |=> (mem_req && mem_we)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> mem_req); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> $stable(mem_addr)); // R10

  AST_STALL_COVERS_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_stall); // R10

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> (cpu_done && !mem_req)); // R10
endmodule

bind assoc_victim_cache avc_checker #(.ADDR_W(ADDR_W)) i_avc_checker (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_stall(cpu_stall), .cpu_done(cpu_done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/test_assoc_victim_cache.sv
`timescale 1ns/1ps
module test_assoc_victim_cache;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_stall, cpu_done, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_vec = 0, n_bad = 0, fills = 0, wait_cnt = 0;
  logic [31:0] bmem [logic [31:0]];

  always #2 clk = ~clk;

  assoc_victim_cache i_assoc_victim_cache (.*);

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  // Memory model: acknowledges on the second cycle of a request.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_req) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          wait_cnt  = 0;
          mem_ready = 1'b1;
          if (mem_we) bmem[mem_addr] = mem_wdata;
          else begin
            mem_rdata = {ref_word(mem_addr + 32'd4), ref_word(mem_addr)};
            fills++;
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd_o, output logic hit_o,
                       output int cyc, output int fd, output logic stall_o);
    int f0;
    f0 = fills;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    stall_o = cpu_stall;
    while (!cpu_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    rd_o  = cpu_rdata;
    hit_o = cpu_hit;
    fd    = fills - f0;
  endtask

  // {we, addr[15:0], wdata, exp_hit, exp_fill}
  localparam int NV = 18;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 16'h0000, 32'h0,          1'b0, 1'b1}, // R3 cold miss, line fetched
    {1'b0, 16'h0004, 32'h0,          1'b1, 1'b0}, // R3 odd word came with the line
    {1'b0, 16'h0008, 32'h0,          1'b0, 1'b1},
    {1'b0, 16'h0010, 32'h0,          1'b0, 1'b1},
    {1'b0, 16'h0018, 32'h0,          1'b0, 1'b1}, // main array now full
    {1'b0, 16'h0000, 32'h0,          1'b1, 1'b0}, // R1 hit refreshes recency
    {1'b0, 16'h0020, 32'h0,          1'b0, 1'b1}, // R2 displaces 0x08 into victim
    {1'b0, 16'h0008, 32'h0,          1'b1, 1'b0}, // R7 victim hit, 0x10 swapped out
    {1'b0, 16'h0010, 32'h0,          1'b1, 1'b0}, // R7 swap moved 0x10 to victim
    {1'b1, 16'h0028, 32'hCAFE0028,   1'b0, 1'b0}, // R5 store alloc, no fetch
    {1'b0, 16'h0028, 32'h0,          1'b1, 1'b0}, // R5 stored word present
    {1'b0, 16'h002C, 32'h0,          1'b0, 1'b1}, // R4 other word still invalid
    {1'b1, 16'h002C, 32'h0BAD002C,   1'b1, 1'b0}, // R8 store hit main
    {1'b0, 16'h002C, 32'h0,          1'b1, 1'b0}, // R8 updated copy
    {1'b1, 16'h0018, 32'h5EED0018,   1'b1, 1'b0}, // R8 store hit in victim
    {1'b0, 16'h0018, 32'h0,          1'b1, 1'b0}, // R8 victim copy updated
    {1'b0, 16'h0020, 32'h0,          1'b1, 1'b0}, // R2 LRU 0x20 went to victim
    {1'b0, 16'h0000, 32'h0,          1'b1, 1'b0}  // R6 displaced line kept in victim
  };

  initial begin
    logic [31:0] rd;
    logic        hit, stl;
    int          cyc, fd;

    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cpu_stall && !cpu_done && !mem_req, "R9", "idle during reset",
        {29'd0, cpu_stall, cpu_done, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done && !mem_req, "R9", "idle after reset",
        {29'd0, cpu_stall, cpu_done, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic        we, eh, ef;
      logic [31:0] a, wd;
      we = VEC[i][50];
      a  = {16'd0, VEC[i][49:34]};
      wd = VEC[i][33:2];
      eh = VEC[i][1];
      ef = VEC[i][0];
      do_op(we, a, wd, rd, hit, cyc, fd, stl);
      chk(hit == eh, eh ? "R7" : "R2", $sformatf("vec %0d hit", i), {31'd0, hit}, {31'd0, eh});
      chk(fd == int'(ef), "R3", $sformatf("vec %0d line reads", i), fd, {31'd0, ef});
      if (!we) chk(rd == ref_word(a), "R3", $sformatf("vec %0d data", i), rd, ref_word(a));
      if (!we && eh) chk(cyc == 1, "R1", $sformatf("vec %0d latency", i), cyc, 32'd1);
      else chk(stl && cyc == 3, "R10", $sformatf("vec %0d stall/latency", i),
               {stl, 31'(cyc)}, {1'b1, 31'd3});
    end

    // Directed: reset clears contents, then victim FIFO overflow.
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_op(1'b0, 32'h18, 32'h0, rd, hit, cyc, fd, stl);
    chk(!hit && fd == 1, "R9", "cached line gone after reset", {31'd0, hit}, 32'd0);
    chk(rd == 32'h5EED0018, "R8", "write-through reached memory", rd, 32'h5EED0018);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = 32'h100 + 32'(k * 8);
      do_op(1'b0, a, 32'h0, rd, hit, cyc, fd, stl);
      chk(!hit && fd == 1, "R2", $sformatf("fill line %h", a), {31'd0, hit}, 32'd0);
    end
    do_op(1'b0, 32'h104, 32'h0, rd, hit, cyc, fd, stl);
    chk(hit && fd == 0 && cyc == 1 && rd == ref_word(32'h104), "R7",
        "victim hit on odd word", rd, ref_word(32'h104));
    do_op(1'b0, 32'h18, 32'h0, rd, hit, cyc, fd, stl);
    chk(!hit && fd == 1, "R6", "oldest victim entry dropped", {31'd0, hit}, 32'd0);
    do_op(1'b0, 32'h108, 32'h0, rd, hit, cyc, fd, stl);
    chk(hit && fd == 0 && rd == ref_word(32'h108), "R6", "younger victim entry kept",
        rd, ref_word(32'h108));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule